// File: doc/BRIEF.md
# Latching Amplifier Fault Shutdown Controller

This block guards a switching audio power stage. It watches three health measurements that arrive as converted codes, each with its own valid strobe: the signed DC offset seen at the load, the supply rail voltage and the heatsink temperature. When any sample falls outside its limit, the block sets a sticky fault. The fault drops the power-stage enable at once and keeps it low until software-independent clear logic accepts an explicit clear request.

A three-bit cause record tells which conditions tripped since the last accepted clear. The three limits are held in registers that come out of reset at the equivalents of ±50 mV offset, 85 % of nominal rail and 80 °C, and they can be reloaded through a small load port. After reset the enable stays low until each of the three measurements has delivered at least one in-range sample.

Top module: `amp_fault_latch`

## Requirements
- R1: During and straight after reset, stage_en_o, fault_o and cause_o are all zero. The limits reset to 50 (offset magnitude), RAIL_NOM*UV_PCT/100 = 1020 (rail) and 80 (temperature).
- R2: stage_en_o rises on the clock edge that samples the last of the three first in-range valid samples. This holds only while no fault is latched.
- R3: An offset sample with ofs_vld high trips when its magnitude is strictly above the offset limit, for either sign. A magnitude equal to the limit does not trip. The sample of -2048 counts as magnitude 2048.
- R4: A rail sample with rail_vld high trips when the unsigned code is strictly below the rail limit. A code equal to the limit does not trip.
- R5: A temperature sample with temp_vld high trips when the unsigned code is strictly above the temperature limit. A code equal to the limit does not trip.
- R6: A measurement code whose valid strobe is low has no effect on fault_o, cause_o or stage_en_o.
- R7: A trip sets fault_o on the edge that samples the tripping sample. While fault_o is high, stage_en_o is low. fault_o stays high after in-range samples return, until a clear is accepted.
- R8: cause_o bit 0 marks offset, bit 1 marks undervoltage and bit 2 marks overtemperature. Bits accumulate until a clear is accepted.
- R9: clr_i is accepted only when the most recent valid sample of every measurement was in range. An accepted clear zeroes fault_o and cause_o, except that a trip sampled in the same cycle still sets its bit and the fault.
- R10: When lim_wr is high, lim_data is loaded into one limit chosen by lim_sel: 0 offset, 1 rail, 2 temperature. lim_sel = 3 changes no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofs_vld | input | 1 | Offset sample strobe |
| ofs_code | input | CODE_W | Signed offset code |
| rail_vld | input | 1 | Rail sample strobe |
| rail_code | input | CODE_W | Unsigned rail voltage code |
| temp_vld | input | 1 | Temperature sample strobe |
| temp_code | input | CODE_W | Unsigned heatsink temperature code |
| lim_wr | input | 1 | Limit load strobe |
| lim_sel | input | 2 | Limit select (0 offset, 1 rail, 2 temperature) |
| lim_data | input | CODE_W | New limit value |
| clr_i | input | 1 | Fault clear request |
| stage_en_o | output | 1 | Power stage / modulator enable |
| fault_o | output | 1 | Latched shutdown |
| cause_o | output | 3 | Sticky trip causes |

## Verification
The assertions assume that each strobe marks a complete, settled code in the cycle it is high. They also assume that a limit reload never lands in the same cycle as a sample it should apply to, because a comparison uses the limit held before that edge. The stimulus drives every code and strobe on the falling edge and holds it for one full cycle. It keeps limit loads in cycles with no strobe, and it returns each measurement to an in-range value before it requests a clear. The only exceptions are the cases that deliberately test a blocked clear and a trip that coincides with a clear.

// File: rtl/amp_fault_latch.sv
module amp_fault_latch #(
  parameter int CODE_W      = 12,
  parameter int OFS_LIM_DEF = 50,
  parameter int RAIL_NOM    = 1200,
  parameter int UV_PCT      = 85,
  parameter int OT_LIM_DEF  = 80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ofs_vld,
  input  logic signed [CODE_W-1:0] ofs_code,
  input  logic                     rail_vld,
  input  logic [CODE_W-1:0]        rail_code,
  input  logic                     temp_vld,
  input  logic [CODE_W-1:0]        temp_code,
  input  logic                     lim_wr,
  input  logic [1:0]               lim_sel,
  input  logic [CODE_W-1:0]        lim_data,
  input  logic                     clr_i,
  output logic                     stage_en_o,
  output logic                     fault_o,
  output logic [2:0]               cause_o
);

  localparam logic [CODE_W-1:0] OFS_DEF = CODE_W'(OFS_LIM_DEF);
  localparam logic [CODE_W-1:0] UV_DEF  = CODE_W'(RAIL_NOM * UV_PCT / 100);
  localparam logic [CODE_W-1:0] OT_DEF  = CODE_W'(OT_LIM_DEF);

  logic [CODE_W-1:0] lim_ofs, lim_uv, lim_ot;
  logic [CODE_W-1:0] ofs_mag;
  logic [2:0] hit, vld, trip, act_q, seen_q;
  logic       fault_q, clr_ok;

  assign ofs_mag = ofs_code[CODE_W-1] ? $unsigned(-ofs_code) : $unsigned(ofs_code);
  assign hit     = {temp_code > lim_ot, rail_code < lim_uv, ofs_mag > lim_ofs};
  assign vld     = {temp_vld, rail_vld, ofs_vld};
  assign trip    = hit & vld;
  assign clr_ok  = clr_i && (act_q == 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_ofs <= OFS_DEF;
      lim_uv  <= UV_DEF;
      lim_ot  <= OT_DEF;
    end else if (lim_wr) begin
      case (lim_sel)
        2'd0:    lim_ofs <= lim_data;
        2'd1:    lim_uv  <= lim_data;
        2'd2:    lim_ot  <= lim_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      seen_q  <= '0;
      fault_q <= 1'b0;
      cause_o <= '0;
    end else begin
      act_q   <= (act_q & ~vld) | trip;
      seen_q  <= seen_q | (vld & ~hit);
      fault_q <= (fault_q & ~clr_ok) | (|trip);
      cause_o <= (clr_ok ? 3'b000 : cause_o) | trip;
    end
  end

  assign fault_o    = fault_q;
  assign stage_en_o = (&seen_q) & ~fault_q;

  assert_en_off_in_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !stage_en_o);
  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && !clr_i |=> fault_o);
  assert_cause_tracks_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o == (cause_o != 3'b000));
  assert_ofs_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_vld && (ofs_mag > lim_ofs) |=> fault_o && cause_o[0]);
  assert_uv_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rail_vld && (rail_code < lim_uv) |=> fault_o && cause_o[1]);
  assert_ot_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    temp_vld && (temp_code > lim_ot) |=> fault_o && cause_o[2]);
  assert_no_strobe_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_vld && !rail_vld && !temp_vld && !clr_i |=> $stable(fault_o) && $stable(cause_o));
  assert_clear_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && clr_i && (act_q != 3'b000) |=> fault_o);
  assert_causes_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

endmodule

// File: tb/amp_fault_latch_tb.sv
module amp_fault_latch_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ofs_vld = 0, rail_vld = 0, temp_vld = 0, lim_wr = 0, clr_i = 0;
  logic signed [11:0] ofs_code = '0;
  logic [11:0] rail_code = 12'd1200, temp_code = 12'd25, lim_data = '0;
  logic [1:0] lim_sel = '0;
  logic stage_en_o, fault_o;
  logic [2:0] cause_o;
  int nchk = 0, nfail = 0;

  always #(CLK_P/2) clk = ~clk;

  amp_fault_latch u_dut (
    .clk(clk), .rst_n(rst_n),
    .ofs_vld(ofs_vld), .ofs_code(ofs_code),
    .rail_vld(rail_vld), .rail_code(rail_code),
    .temp_vld(temp_vld), .temp_code(temp_code),
    .lim_wr(lim_wr), .lim_sel(lim_sel), .lim_data(lim_data),
    .clr_i(clr_i), .stage_en_o(stage_en_o), .fault_o(fault_o), .cause_o(cause_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_state(input string req, input int f, input int c, input int en);
    chk({req, " fault"}, int'(fault_o), f);
    chk({req, " cause"}, int'(cause_o), c);
    chk({req, " enable"}, int'(stage_en_o), en);
  endtask

  // which: 0 offset, 1 rail, 2 temperature
  task automatic sample(input int which, input int v, input bit with_clr = 0);
    case (which)
      0: begin ofs_code = 12'(v); ofs_vld = 1; end
      1: begin rail_code = 12'(v); rail_vld = 1; end
      default: begin temp_code = 12'(v); temp_vld = 1; end
    endcase
    clr_i = with_clr;
    @(negedge clk);
    ofs_vld = 0; rail_vld = 0; temp_vld = 0; clr_i = 0;
  endtask

  task automatic clear();
    clr_i = 1;
    @(negedge clk);
    clr_i = 0;
  endtask

  task automatic set_lim(input int sel, input int v);
    lim_sel = 2'(sel); lim_data = 12'(v); lim_wr = 1;
    @(negedge clk);
    lim_wr = 0;
  endtask

  task automatic restore();
    sample(0, 0); sample(1, 1200); sample(2, 25); clear();
  endtask

  // sweep one measurement: trip rule computed arithmetically
  task automatic sweep(input int which, input int lo, input int hi, input int lim);
    for (int v = lo; v <= hi; v++) begin
      bit t;
      case (which)
        0: t = (v > lim) || (v < -lim);
        1: t = (v < lim);
        default: t = (v > lim);
      endcase
      sample(which, v);
      case (which)
        0: expect_state("R3 offset sweep", int'(t), t ? 1 : 0, int'(!t));
        1: expect_state("R4 rail sweep", int'(t), t ? 2 : 0, int'(!t));
        default: expect_state("R5 temp sweep", int'(t), t ? 4 : 0, int'(!t));
      endcase
      restore();
      if (t) expect_state("R9 clear after sweep trip", 0, 0, 1);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    expect_state("R1 in reset", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    expect_state("R1 after reset", 0, 0, 0);

    sample(0, 0);
    chk("R2 enable after offset only", int'(stage_en_o), 0);
    sample(1, 1200);
    chk("R2 enable after rail", int'(stage_en_o), 0);
    sample(2, 25);
    chk("R2 enable after all three", int'(stage_en_o), 1);

    // R1 default limits, R3/R4/R5 boundaries via sweeps
    sweep(0, -120, 120, 50);
    sweep(0, -2048, -2046, 50);
    sweep(1, 980, 1060, 1020);
    sweep(2, 50, 110, 80);

    // R6: codes without strobes are ignored
    ofs_code = 12'sd500; rail_code = 12'd0; temp_code = 12'd4000;
    @(negedge clk); @(negedge clk);
    expect_state("R6 no strobe", 0, 0, 1);
    ofs_code = '0; rail_code = 12'd1200; temp_code = 12'd25;

    // R7: latch holds after condition goes away
    sample(2, 95);
    sample(2, 30);
    @(negedge clk); @(negedge clk);
    expect_state("R7 latch holds", 1, 4, 0);
    restore();

    // R8: causes accumulate
    sample(1, 900);
    sample(2, 90);
    expect_state("R8 accumulate", 1, 6, 0);
    sample(0, -70);
    expect_state("R8 all three", 1, 7, 0);

    // R9: clear blocked while the last sample of a measurement is bad
    sample(0, 0); sample(2, 25);
    clear();
    expect_state("R9 clear blocked by rail", 1, 7, 0);
    sample(1, 1200);
    clear();
    expect_state("R9 clear accepted", 0, 0, 1);
    // R9: trip in the same cycle as an accepted clear wins
    sample(0, 60, 1'b1);
    expect_state("R9 trip beats clear", 1, 1, 0);
    restore();
    expect_state("R9 restored", 0, 0, 1);

    // R10: limit loads
    set_lim(0, 10);
    sweep(0, -14, 14, 10);
    set_lim(1, 600);
    sweep(1, 595, 605, 600);
    set_lim(2, 40);
    sweep(2, 35, 45, 40);
    set_lim(3, 0);
    sample(0, 10); sample(1, 600); sample(2, 40);
    expect_state("R10 select 3 ignored at limits", 0, 0, 1);
    sample(0, 11);
    expect_state("R10 select 3 kept offset limit", 1, 1, 0);
    restore();
    expect_state("R10 final", 0, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule